// File: doc/BRIEF.md
# Broadcast Write Acknowledge Sequencer

This block is the bus-master end of a synchronous write that goes to several slave processors at the same time. All slaves share one acknowledge line. The line is wired-AND, so it reads high only when every slave can take the data. The sequencer accepts a request that carries an address and a data word. It then drives the address, data and write strobe onto the bus, and watches the acknowledge line to decide in which cycle the write ends.

Without the wait state, a write that sees acknowledge high in its first bus cycle ends in that same cycle. If acknowledge is low at the start, the write lasts at least three cycles. A configuration input, captured with each request, adds a fixed wait state. In that mode the master neither samples nor keeps the acknowledge line during the first two bus cycles, so every write lasts at least three cycles. After the minimum length, the write ends in the first cycle that sees acknowledge high. A one-cycle completion strobe marks that final cycle, and a busy flag covers the whole write.

Top module: `bcast_write_seq`

## Requirements
- R1: With the captured wait-state bit clear and `ack_in` high in bus cycle 1 (the first cycle after acceptance), `done` is high in cycle 1 and the write has length 1.
- R2: With the wait-state bit clear and `ack_in` low in cycle 1, a high `ack_in` in cycle 2 is ignored. The write ends in the first cycle numbered 3 or higher in which `ack_in` is high.
- R3: With the wait-state bit set, `ack_in` is ignored and `ack_oe` is low in cycles 1 and 2. From cycle 3 on, `ack_oe` is high and the write ends in the first cycle with `ack_in` high, so every such write lasts at least 3 cycles. With the bit clear, `ack_oe` is high in every bus cycle.
- R4: `wait_en` is captured on the edge that accepts a request. Changing it during the write has no effect on the write's length or on `ack_oe`.
- R5: `busy` is high from the first bus cycle through the cycle that carries `done`, and low in the cycle after it. `done` is a single-cycle pulse in the final bus cycle only.
- R6: Throughout a write, `bus_addr` and `bus_data` hold the accepted request, and `bus_we`, `addr_oe` and `data_oe` are all high. While idle, these three enables are low.
- R7: A `req_valid` raised while `busy` is high is ignored. The current write's address and length do not change, and no write follows once it ends.
- R8: An active-low `rst_n` asynchronously returns the block to idle, with `busy`, `done`, `bus_we`, `addr_oe`, `data_oe` and `ack_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_en | input | 1 | Wait-state mode, captured when a request is accepted |
| req_valid | input | 1 | Write request, accepted only when idle |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Request data |
| ack_in | input | 1 | Shared wired-AND slave acknowledge |
| bus_addr | output | ADDR_W | Address driven to the slaves |
| bus_data | output | DATA_W | Data driven to the slaves |
| bus_we | output | 1 | Write strobe |
| addr_oe | output | 1 | Address drive enable |
| data_oe | output | 1 | Data drive enable |
| ack_oe | output | 1 | Master samples and keeps the acknowledge line |
| busy | output | 1 | Write in progress |
| done | output | 1 | Single-cycle completion strobe in the final cycle |

## Verification
A wrong cycle count or a wrong captured mode bit changes the position of the `done` pulse. It also changes when `ack_oe` rises, within the first three bus cycles of the write, so each length-pattern vector measures the write length directly. A stuck state register keeps `busy` and the drive enables high in the cycle after `done`. A wrongly loaded holding register shows a changed `bus_addr` in the very next cycle after a request is raised during a write.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic {
    BWS_IDLE   = 1'b0,
    BWS_ACTIVE = 1'b1
  } bws_state_e;
endpackage

// File: rtl/bws_req_hold.sv
module bws_req_hold #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_wait,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_data,
  output logic              q_wait
);
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  logic              wait_d;

  always_comb begin
    addr_d = q_addr;
    data_d = q_data;
    wait_d = q_wait;
    if (load) begin
      addr_d = in_addr;
      data_d = in_data;
      wait_d = in_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr <= '0;
      q_data <= '0;
      q_wait <= 1'b0;
    end else begin
      q_addr <= addr_d;
      q_data <= data_d;
      q_wait <= wait_d;
    end
  end
endmodule

// File: rtl/bws_cycle_ctr.sv
module bws_cycle_ctr #(
  parameter int MIN_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic at_first,
  output logic at_last
);
  localparam int CW = (MIN_CYCLES > 1) ? $clog2(MIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign at_first = (cnt_q == '0);
  assign at_last  = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) cnt_d = '0;
    else if (en && !at_last) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bws_ctrl.sv
module bws_ctrl
  import bws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic ack_in,
  input  logic wait_q,
  input  logic at_first,
  input  logic at_last,
  output logic load,
  output logic busy,
  output logic done,
  output logic ack_oe
);
  bws_state_e state_q, state_d;

  assign busy   = (state_q == BWS_ACTIVE);
  assign load   = (state_q == BWS_IDLE) && req_valid;
  assign ack_oe = busy && (!wait_q || at_last);
  assign done   = busy && ack_in && ((at_first && !wait_q) || at_last);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BWS_IDLE:   if (req_valid) state_d = BWS_ACTIVE;
      BWS_ACTIVE: if (done)      state_d = BWS_IDLE;
      default:                   state_d = BWS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BWS_IDLE;
    else        state_q <= state_d;
  end

  // R5: strobe only inside a write, and the write ends right after it
  assert_done_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_idle_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R3: the wait window keeps the acknowledge line unused
  assert_wait_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wait_q && !at_last) |-> (!ack_oe && !done));
endmodule

// File: rtl/bcast_write_seq.sv
module bcast_write_seq #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int MIN_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              ack_in,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_we,
  output logic              addr_oe,
  output logic              data_oe,
  output logic              ack_oe,
  output logic              busy,
  output logic              done
);
  logic load;
  logic wait_q;
  logic at_first;
  logic at_last;

  bws_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .in_addr (req_addr),
    .in_data (req_data),
    .in_wait (wait_en),
    .q_addr  (bus_addr),
    .q_data  (bus_data),
    .q_wait  (wait_q)
  );

  bws_cycle_ctr #(.MIN_CYCLES(MIN_CYCLES)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (load),
    .en       (busy),
    .at_first (at_first),
    .at_last  (at_last)
  );

  bws_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ack_in    (ack_in),
    .wait_q    (wait_q),
    .at_first  (at_first),
    .at_last   (at_last),
    .load      (load),
    .busy      (busy),
    .done      (done),
    .ack_oe    (ack_oe)
  );

  assign bus_we  = busy;
  assign addr_oe = busy;
  assign data_oe = busy;

  // R2: no completion in the middle cycles of a stalled write
  assert_no_mid_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_first && !at_last) |-> !done);
  // R6: request stays on the bus until the final cycle
  assert_hold_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(bus_addr) && $stable(bus_data) && busy));
  // R6: enables low while idle
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_we && !addr_oe && !data_oe && !ack_oe));
endmodule

// File: tb/tb_bcast_write_seq.sv
module tb_bcast_write_seq;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_en = 1'b0, req_valid = 1'b0, ack_in = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic bus_we, addr_oe, data_oe, ack_oe, busy, done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bcast_write_seq #(.ADDR_W(AW), .DATA_W(DW), .MIN_CYCLES(3)) dut (
    .clk(clk), .rst_n(rst_n), .wait_en(wait_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_data(req_data), .ack_in(ack_in),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_we(bus_we),
    .addr_oe(addr_oe), .data_oe(data_oe), .ack_oe(ack_oe),
    .busy(busy), .done(done)
  );

  // {wait, flip_wait, inject_req, ack pattern (bit0 = cycle 1), expected length}
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'b1111_1111, 4'd1},  // R1
    {1'b0, 1'b0, 1'b0, 8'b1111_1110, 4'd3},  // R2 cycle 2 ack ignored
    {1'b0, 1'b0, 1'b0, 8'b1110_0000, 4'd6},  // R2 long stall
    {1'b0, 1'b0, 1'b0, 8'b1111_1100, 4'd3},  // R2
    {1'b1, 1'b0, 1'b0, 8'b1111_1111, 4'd3},  // R3
    {1'b1, 1'b0, 1'b0, 8'b1111_0011, 4'd5},  // R3
    {1'b1, 1'b0, 1'b1, 8'b1111_1000, 4'd4},  // R7
    {1'b1, 1'b1, 1'b0, 8'b1111_1111, 4'd3},  // R4
    {1'b0, 1'b1, 1'b0, 8'b1111_1111, 4'd1},  // R4
    {1'b0, 1'b0, 1'b1, 8'b1111_0000, 4'd5}   // R7
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int idx);
    logic w, flip, inj;
    logic [7:0] pat;
    int exp_len, len, hold_bad, oe_bad;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    {w, flip, inj, pat} = VEC[idx][14:4];
    exp_len = int'(VEC[idx][3:0]);
    a = AW'(16'h1000 + idx * 16'h0111);
    d = DW'(32'hA5000000 + idx * 32'h00010203);
    len = 0; hold_bad = 0; oe_bad = 0;
    @(negedge clk);
    wait_en = w; req_valid = 1'b1; req_addr = a; req_data = d;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        req_addr = ~a; req_data = ~d;
        if (flip) wait_en = ~w;
      end
      if (inj && k == 2) req_valid = 1'b1;
      if (inj && k == 3) req_valid = 1'b0;
      ack_in = pat[k-1];
      #1;
      if (!(busy && bus_we && addr_oe && data_oe && bus_addr == a && bus_data == d))
        hold_bad++;
      if (ack_oe != !(w && k < 3)) oe_bad++;
      if (done) begin
        len = k;
        break;
      end
    end
    req_valid = 1'b0;
    check(len == exp_len, (w ? "R3 length" : (exp_len == 1 ? "R1 length" : "R2 length")),
          len, exp_len);
    check(hold_bad == 0, "R6 hold", hold_bad, 0);
    check(oe_bad == 0, (flip ? "R4 ack_oe" : "R3 ack_oe"), oe_bad, 0);
    @(negedge clk);
    ack_in = 1'b0;
    #1;
    check(!busy && !done && !bus_we && !addr_oe && !data_oe,
          (inj ? "R7 idle after" : "R5 idle after"), int'(busy), 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #5;
    // R8 reset state
    check(!busy && !done && !bus_we && !addr_oe && !data_oe && !ack_oe,
          "R8 reset", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(i);

    // R5: done is a single pulse even with ack held high
    @(negedge clk);
    wait_en = 1'b0; ack_in = 1'b1; req_valid = 1'b1; req_addr = 16'h0042;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(done && busy, "R5 pulse", int'(done), 1);
    @(negedge clk);
    #1;
    check(!done && !busy, "R5 single", int'(done), 0);

    // R8: asynchronous reset in the middle of a write
    @(negedge clk);
    wait_en = 1'b1; ack_in = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(busy, "R8 write started", int'(busy), 1);
    rst_n = 1'b0;
    #0.5;
    check(!busy && !done && !bus_we && !addr_oe && !data_oe && !ack_oe,
          "R8 async", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!busy, "R8 stays idle", int'(busy), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule